// File: doc/BRIEF.md
# Serial Carry-Save to Binary Digit Converter

This block turns a redundant operand, held as two unsigned words whose sum is the value, into plain binary digits. It delivers them least significant first, two adjacent digits per clock cycle. An iterative modular multiplier that scans its multiplier operand one or two bits per iteration uses it this way. The multiplier loads the two words once, reads the two lowest pending digits, and then advances. A feedback bypass input says whether the multiplier consumed one digit or two in that iteration.

Internally, two shift registers hold the two words, each widened by two zero bits above the operand width. Two chained one-bit full adders add the lowest two bit pairs of the registers together with a stored carry. A step of one position keeps the carry out of the lower adder. A step of two positions keeps the carry out of the upper adder. Because the digit outputs come straight from the registers through the adders, the next pair of digits is valid in the cycle after each step.

Top module: `csDigitSerializer`

## Requirements
- R1: A load stores both operands zero-extended by two bits and clears the stored carry. In the following cycle, digitLo and digitHi show bits 0 and 1 of opA1 + opA2.
- R2: Whenever the converter sits at digit position p, digitLo equals bit p of opA1 + opA2 and digitHi equals bit p+1. The digits collected over all steps rebuild the full sum exactly.
- R3: An advance with bypass = 1 moves the position forward by two digits. The carry out of the upper full adder is kept.
- R4: An advance with bypass = 0 moves the position forward by one digit. The carry out of the lower full adder is kept.
- R5: Zeros enter at the top of both registers. The two most significant register bits are always 0. Once the position passes the top of the sum, both digits read 0.
- R6: Without advance or load, the registers and the carry keep their values. Changing bypass alone leaves both digits unchanged.
- R7: When load and advance are high in the same cycle, the load wins and the position returns to digit 0 of the new operands.
- R8: After reset, both registers and the carry are 0, so both digits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Parallel load of both operand words |
| opA1 | input | OPW | First word of the redundant operand |
| opA2 | input | OPW | Second word of the redundant operand |
| advance | input | 1 | Step strobe from the multiplier |
| bypass | input | 1 | Step size select: 1 = two digits, 0 = one digit |
| digitLo | output | 1 | Digit at the current position |
| digitHi | output | 1 | Digit at the current position plus one |

## Verification
A wrong stored carry, a wrong shift distance or a stray nonzero top bit makes the two digits differ from the bits of the true sum at the current position. The error shows at the ports in the first cycle after the step that caused it. Every digit is therefore compared against the bench's own sum at a position that the bench tracks itself. The operand pairs are chosen to cause long carry chains, and the bypass patterns are random. A carry error then also persists into later digits and breaks the rebuilt total.

// File: rtl/csDigitPkg.sv
package csDigitPkg;
  typedef struct packed {
    logic load;
    logic stepOne;
    logic stepTwo;
  } stepCtrlT;
endpackage

// File: rtl/csFullAdder.sv
module csFullAdder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);
  always_comb begin
    sum  = a ^ b ^ cin;
    cout = (a & b) | (a & cin) | (b & cin);
  end
endmodule

// File: rtl/csDigitCtrl.sv
module csDigitCtrl
  import csDigitPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     loadEn,
  input  logic     advance,
  input  logic     bypass,
  output stepCtrlT strobes
);
  // Load wins over a step issued in the same cycle (R7).
  always_comb begin
    strobes.load    = loadEn;
    strobes.stepOne = !loadEn && advance && !bypass;
    strobes.stepTwo = !loadEn && advance && bypass;
  end

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.stepOne, strobes.stepTwo}))
    else $error("strobes not exclusive");

  p_load_prio_r7: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> (!strobes.stepOne && !strobes.stepTwo))
    else $error("step issued during load");
endmodule

// File: rtl/csDigitDatapath.sv
module csDigitDatapath
  import csDigitPkg::*;
#(
  parameter int OPW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  stepCtrlT       strobes,
  input  logic [OPW-1:0] inA1,
  input  logic [OPW-1:0] inA2,
  output logic           digitLo,
  output logic           digitHi
);
  localparam int EXT    = 2;
  localparam int W      = OPW + EXT;
  localparam int DIGITS = 2;

  logic [W-1:0] regA1, regA2;
  logic         carryQ;
  logic [DIGITS:0]   carryChain;
  logic [DIGITS-1:0] sumBits;

  assign carryChain[0] = carryQ;

  for (genvar d = 0; d < DIGITS; d++) begin : g_adder
    csFullAdder u_fa (
      .a   (regA1[d]),
      .b   (regA2[d]),
      .cin (carryChain[d]),
      .sum (sumBits[d]),
      .cout(carryChain[d+1])
    );
  end

  assign digitLo = sumBits[0];
  assign digitHi = sumBits[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA1  <= '0;
      regA2  <= '0;
      carryQ <= 1'b0;
    end else if (strobes.load) begin
      regA1  <= {{EXT{1'b0}}, inA1};
      regA2  <= {{EXT{1'b0}}, inA2};
      carryQ <= 1'b0;
    end else if (strobes.stepTwo) begin
      regA1  <= regA1 >> 2;
      regA2  <= regA2 >> 2;
      carryQ <= carryChain[2];
    end else if (strobes.stepOne) begin
      regA1  <= regA1 >> 1;
      regA2  <= regA2 >> 1;
      carryQ <= carryChain[1];
    end
  end

  p_load_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (carryQ == 1'b0))
    else $error("carry not cleared by load");

  p_two_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepTwo |=> (regA1 == ($past(regA1) >> 2)) && (regA2 == ($past(regA2) >> 2))
                        && (carryQ == $past(carryChain[2])))
    else $error("double step wrong");

  p_one_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepOne |=> (regA1 == ($past(regA1) >> 1)) && (regA2 == ($past(regA2) >> 1))
                        && (carryQ == $past(carryChain[1])))
    else $error("single step wrong");

  p_top_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regA1[W-1 -: EXT] == '0) && (regA2[W-1 -: EXT] == '0))
    else $error("top guard bits not zero");

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load || strobes.stepOne || strobes.stepTwo)
      |=> $stable(regA1) && $stable(regA2) && $stable(carryQ))
    else $error("state moved without strobe");
endmodule

// File: rtl/csDigitSerializer.sv
module csDigitSerializer
  import csDigitPkg::*;
#(
  parameter int OPW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           loadEn,
  input  logic [OPW-1:0] opA1,
  input  logic [OPW-1:0] opA2,
  input  logic           advance,
  input  logic           bypass,
  output logic           digitLo,
  output logic           digitHi
);
  stepCtrlT strobes;

  csDigitCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .loadEn (loadEn),
    .advance(advance),
    .bypass (bypass),
    .strobes(strobes)
  );

  csDigitDatapath #(.OPW(OPW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .inA1   (opA1),
    .inA2   (opA2),
    .digitLo(digitLo),
    .digitHi(digitHi)
  );
endmodule

// File: tb/test_csDigitSerializer.sv
`timescale 1ns/1ps
module test_csDigitSerializer;
  localparam int OPW = 16;
  localparam int W   = OPW + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [OPW-1:0] opA1 = '0, opA2 = '0;
  logic advance = 1'b0, bypass = 1'b0;
  logic digitLo, digitHi;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  longint unsigned expSum;
  int pos;

  csDigitSerializer #(.OPW(OPW)) i_csDigitSerializer (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .opA1(opA1), .opA2(opA2),
    .advance(advance), .bypass(bypass), .digitLo(digitLo), .digitHi(digitHi)
  );

  always #2.5 clk = ~clk;

  function automatic logic bitAt(longint unsigned v, int p);
    if (p > 63) return 1'b0;
    return v[p];
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pos %0d actual %b expected %b", req, pos, act, exp);
    end
  endtask

  task automatic checkPos(string req);
    check(req, {digitHi, digitLo}, {bitAt(expSum, pos + 1), bitAt(expSum, pos)});
  endtask

  task automatic doLoad(logic [OPW-1:0] a, logic [OPW-1:0] b);
    @(negedge clk);
    loadEn = 1'b1; opA1 = a; opA2 = b;
    @(negedge clk);
    loadEn = 1'b0;
    expSum = longint'(a) + longint'(b);
    pos = 0;
  endtask

  task automatic step(logic byp);
    @(negedge clk);
    advance = 1'b1; bypass = byp;
    @(negedge clk);
    advance = 1'b0;
    pos += byp ? 2 : 1;
  endtask

  task automatic testReset();
    pos = 0; expSum = 0;
    checkPos("R8 reset digits");
  endtask

  task automatic testLoad();
    doLoad('1, '1);
    checkPos("R1 load all ones");
    doLoad(16'h0001, 16'h0001);
    checkPos("R1 load small");
  endtask

  task automatic testSingleSteps();
    doLoad(16'hFFFF, 16'h0001);
    while (pos < W + 1) begin
      step(1'b0);
      checkPos("R4 single step");
    end
  endtask

  task automatic testDoubleSteps();
    doLoad(16'hAAAA, 16'h5556);
    while (pos < W + 1) begin
      step(1'b1);
      checkPos("R3 double step");
    end
  endtask

  task automatic testRandomMix();
    for (int n = 0; n < 40; n++) begin
      longint unsigned rebuilt = 0;
      logic [OPW-1:0] a = OPW'($urandom);
      logic [OPW-1:0] b = OPW'($urandom);
      if (n == 0) begin a = '1; b = '1; end
      doLoad(a, b);
      while (pos < W) begin
        logic byp = 1'($urandom);
        rebuilt |= longint'(digitLo) << pos;
        if (byp) rebuilt |= longint'(digitHi) << (pos + 1);
        step(byp);
        checkPos(byp ? "R3 random step" : "R4 random step");
      end
      check("R2 rebuilt sum", {1'b0, rebuilt == expSum}, 2'b01);
    end
  endtask

  task automatic testHold();
    doLoad(16'h1234, 16'hFEDC);
    step(1'b1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      bypass = ~bypass;
      checkPos("R6 hold");
    end
  endtask

  task automatic testLoadPriority();
    doLoad(16'h00FF, 16'h0F0F);
    step(1'b0);
    @(negedge clk);
    loadEn = 1'b1; advance = 1'b1; bypass = 1'b1;
    opA1 = 16'h8001; opA2 = 16'h7FFF;
    @(negedge clk);
    loadEn = 1'b0; advance = 1'b0;
    expSum = longint'(16'h8001) + longint'(16'h7FFF);
    pos = 0;
    checkPos("R7 load beats advance");
  endtask

  task automatic testDrain();
    doLoad('1, '1);
    for (int s = 0; s < 12; s++) step(1'b1);
    check("R5 drained zeros", {digitHi, digitLo}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoad();
    testSingleSteps();
    testDoubleSteps();
    testHold();
    testLoadPriority();
    testDrain();
    testRandomMix();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule